// File: doc/BRIEF.md
# Two-Read One-Write Register Bank with Per-Port Address Sourcing

This block is the operand store of a multi-cycle processor datapath. It holds sixteen 16-bit words. The lower eight are the registers a program can name. The upper eight are scratch locations that the control sequencer uses to carry values from one step of an instruction to the next. The block has one write port and two independent read ports, which drive operand bus A and operand bus B.

Each port takes two address sources: a 3-bit register field taken from the held instruction, and a 4-bit field from the current control word. The top bit of the control field picks the source. When that bit is clear, the port addresses one of the lower eight registers, using the instruction field with a zero placed above it. When that bit is set, the 4-bit control field is itself the address, and it always falls in the scratch half. Writes take effect on the rising clock edge. Reads are combinational. A synchronous reset clears every location.

Top module: `opstore_rf`

## Requirements
- R1: A synchronous reset clears all sixteen 16-bit locations, so every address on either read port returns 0x0000 after the reset.
- R2: When dst_sel[3] is 0, the write targets location {1'b0, dst_ir}, which is one of locations 0 to 7.
- R3: When dst_sel[3] is 1, the write targets location dst_sel, which is one of 8 to 15, and dst_ir has no effect.
- R4: Read port A returns location {1'b0, a_ir} when a_sel[3] is 0, and location a_sel when a_sel[3] is 1.
- R5: Read port B returns location {1'b0, b_ir} when b_sel[3] is 0, and location b_sel when b_sel[3] is 1.
- R6: A location changes only at a rising edge where wr_en is 1. With wr_en at 0, wr_data has no effect on any location.
- R7: Reads are combinational. During a cycle that writes a location, a port reading that location shows the old value until the edge, and the new value after it.
- R8: Both read ports may address the same location, or different ones, in the same cycle without affecting each other.
- R9: Reset takes priority over a write requested in the same cycle.
- R10: When the top bit of a control field is 0, its lower three bits have no effect on the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable |
| dst_sel | input | 4 | Control-word destination field |
| dst_ir | input | 3 | Instruction destination field |
| a_sel | input | 4 | Control-word field for read port A |
| a_ir | input | 3 | Instruction field for read port A |
| b_sel | input | 4 | Control-word field for read port B |
| b_ir | input | 3 | Instruction field for read port B |
| wr_data | input | 16 | Data to write |
| bus_a | output | 16 | Read port A data |
| bus_b | output | 16 | Read port B data |

## Verification
Four properties are checked on every cycle. After a write, a read port that resolves to the written location returns the written data. With no write, a port held on the same location keeps its value. Two ports that resolve to the same location agree. After reset, both ports read zero. Other behaviour can only be shown by the bench's scenarios: that the wrong half of the bank is never reached, that unused low bits of a control field and the ignored instruction field really have no effect, that the old value is visible before the write edge, and that reset takes priority over a write.

// File: rtl/rf_pkg.sv
package rf_pkg;
   localparam int DATA_W_DEF   = 16;
   localparam int IR_FLD_W_DEF = 3;

   typedef enum int {
      PORT_DST = 0,
      PORT_A   = 1,
      PORT_B   = 2
   } rf_port_e;

   localparam int NUM_PORTS = 3;
endpackage

// File: rtl/rf_addr_resolve.sv
module rf_addr_resolve #(
   parameter int IR_W = rf_pkg::IR_FLD_W_DEF,
   localparam int CTL_W = IR_W + 1
) (
   input  logic [CTL_W-1:0] ctl,
   input  logic [IR_W-1:0]  ir,
   output logic [CTL_W-1:0] addr
);
   // top bit of the control field picks literal scratch index or IR field
   always_comb begin
      if (ctl[CTL_W-1]) addr = ctl;
      else              addr = {1'b0, ir};
   end
endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
   parameter int DATA_W = rf_pkg::DATA_W_DEF,
   parameter int ADDR_W = rf_pkg::IR_FLD_W_DEF + 1,
   parameter int NUM_RD = 2,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           we,
   input  logic [ADDR_W-1:0]              waddr,
   input  logic [DATA_W-1:0]              wdata,
   input  logic [NUM_RD-1:0][ADDR_W-1:0]  raddr,
   output logic [NUM_RD-1:0][DATA_W-1:0]  rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   // reset wins over write
   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      assign rdata[p] = mem[raddr[p]];
   end
endmodule

// File: rtl/opstore_rf.sv
module opstore_rf #(
   parameter int DATA_W   = rf_pkg::DATA_W_DEF,
   parameter int IR_FLD_W = rf_pkg::IR_FLD_W_DEF,
   localparam int CTL_W   = IR_FLD_W + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [CTL_W-1:0]  dst_sel,
   input  logic [IR_FLD_W-1:0] dst_ir,
   input  logic [CTL_W-1:0]  a_sel,
   input  logic [IR_FLD_W-1:0] a_ir,
   input  logic [CTL_W-1:0]  b_sel,
   input  logic [IR_FLD_W-1:0] b_ir,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] bus_a,
   output logic [DATA_W-1:0] bus_b
);
   import rf_pkg::*;

   if (DATA_W < 1) begin : g_bad_data_w
      $error("opstore_rf: DATA_W must be at least 1");
   end
   if (IR_FLD_W < 1 || IR_FLD_W > 6) begin : g_bad_ir_w
      $error("opstore_rf: IR_FLD_W must lie in 1..6");
   end

   logic [NUM_PORTS-1:0][CTL_W-1:0]    sel_v;
   logic [NUM_PORTS-1:0][IR_FLD_W-1:0] ir_v;
   logic [NUM_PORTS-1:0][CTL_W-1:0]    addr_v;
   logic [1:0][CTL_W-1:0]              rd_addr;
   logic [1:0][DATA_W-1:0]             rd_data;

   assign sel_v[PORT_DST] = dst_sel;
   assign sel_v[PORT_A]   = a_sel;
   assign sel_v[PORT_B]   = b_sel;
   assign ir_v[PORT_DST]  = dst_ir;
   assign ir_v[PORT_A]    = a_ir;
   assign ir_v[PORT_B]    = b_ir;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_res
      rf_addr_resolve #(.IR_W(IR_FLD_W)) u_res (
         .ctl  (sel_v[p]),
         .ir   (ir_v[p]),
         .addr (addr_v[p])
      );
   end

   assign rd_addr[0] = addr_v[PORT_A];
   assign rd_addr[1] = addr_v[PORT_B];

   rf_bank #(.DATA_W(DATA_W), .ADDR_W(CTL_W), .NUM_RD(2)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .we    (wr_en),
      .waddr (addr_v[PORT_DST]),
      .wdata (wr_data),
      .raddr (rd_addr),
      .rdata (rd_data)
   );

   assign bus_a = rd_data[0];
   assign bus_b = rd_data[1];

   // R7 / R4: a location written last cycle is seen on port A
   p_wr_visible_a_r4: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(wr_en) && addr_v[PORT_A] == $past(addr_v[PORT_DST]))
      |-> bus_a == $past(wr_data));

   // R5: same for port B
   p_wr_visible_b_r5: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(wr_en) && addr_v[PORT_B] == $past(addr_v[PORT_DST]))
      |-> bus_b == $past(wr_data));

   // R6: no write, same location -> same value
   p_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(wr_en) && addr_v[PORT_A] == $past(addr_v[PORT_A]))
      |-> bus_a == $past(bus_a));

   // R8: ports on the same location agree
   p_ports_agree_r8: assert property (@(posedge clk) disable iff (rst)
      (addr_v[PORT_A] == addr_v[PORT_B]) |-> bus_a == bus_b);

   // R1: right after reset both ports read zero
   p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (bus_a == '0 && bus_b == '0));
endmodule

// File: tb/opstore_rf_bench.sv
module opstore_rf_bench;
   logic        clk = 1'b0;
   logic        rst;
   logic        wr_en;
   logic [3:0]  dst_sel, a_sel, b_sel;
   logic [2:0]  dst_ir, a_ir, b_ir;
   logic [15:0] wr_data;
   logic [15:0] bus_a, bus_b;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   opstore_rf u_opstore_rf (
      .clk(clk), .rst(rst), .wr_en(wr_en),
      .dst_sel(dst_sel), .dst_ir(dst_ir),
      .a_sel(a_sel), .a_ir(a_ir),
      .b_sel(b_sel), .b_ir(b_ir),
      .wr_data(wr_data), .bus_a(bus_a), .bus_b(bus_b)
   );

   typedef struct packed {
      logic        we;
      logic [3:0]  ds;
      logic [2:0]  di;
      logic [3:0]  as;
      logic [2:0]  ai;
      logic [3:0]  bs;
      logic [2:0]  bi;
      logic [15:0] wd;
      logic [15:0] ea;
      logic [15:0] eb;
   } vec_t;

   localparam int NV = 11;
   // expected values are the bus values seen before the row's write edge
   localparam vec_t VECS [NV] = '{
      '{1'b1, 4'b0010, 3'd3, 4'b0000, 3'd3, 4'b1011, 3'd0, 16'h1111, 16'h0000, 16'h0000}, // R2 R10 R7
      '{1'b1, 4'b1011, 3'd3, 4'b0111, 3'd3, 4'b1011, 3'd0, 16'h2222, 16'h1111, 16'h0000}, // R3 R10 R7
      '{1'b0, 4'b1100, 3'd0, 4'b1011, 3'd0, 4'b0000, 3'd3, 16'hDEAD, 16'h2222, 16'h1111}, // R4 R5 R3
      '{1'b1, 4'b0000, 3'd7, 4'b1100, 3'd0, 4'b0000, 3'd3, 16'h7777, 16'h0000, 16'h1111}, // R6
      '{1'b1, 4'b1111, 3'd0, 4'b0000, 3'd7, 4'b1111, 3'd0, 16'hF0F0, 16'h7777, 16'h0000}, // R2 R3
      '{1'b0, 4'b0000, 3'd0, 4'b1111, 3'd0, 4'b1111, 3'd0, 16'h5555, 16'hF0F0, 16'hF0F0}, // R8
      '{1'b1, 4'b1000, 3'd0, 4'b0000, 3'd0, 4'b1000, 3'd0, 16'h8888, 16'h0000, 16'h0000}, // R4 R5
      '{1'b1, 4'b0000, 3'd0, 4'b1000, 3'd0, 4'b0000, 3'd0, 16'h0101, 16'h8888, 16'h0000}, // R3 R4
      '{1'b0, 4'b0000, 3'd0, 4'b0110, 3'd0, 4'b1000, 3'd0, 16'h0000, 16'h0101, 16'h8888}, // R10
      '{1'b1, 4'b0000, 3'd7, 4'b0000, 3'd7, 4'b0111, 3'd7, 16'h1234, 16'h7777, 16'h7777}, // R7
      '{1'b0, 4'b0000, 3'd0, 4'b0000, 3'd7, 4'b1011, 3'd0, 16'h0000, 16'h1234, 16'h2222}  // R7 R8
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic we, input logic [3:0] ds, input logic [2:0] di,
                        input logic [3:0] as, input logic [2:0] ai,
                        input logic [3:0] bs, input logic [2:0] bi,
                        input logic [15:0] wd);
      wr_en = we; dst_sel = ds; dst_ir = di;
      a_sel = as; a_ir = ai; b_sel = bs; b_ir = bi; wr_data = wd;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      rst = 1'b1;
      drive(1'b0, 4'd0, 3'd0, 4'd0, 3'd0, 4'd0, 3'd0, 16'h0);
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1;
      // R1: every location reads zero after reset
      for (int i = 0; i < 8; i++) begin
         a_ir = 3'(i); a_sel = 4'b0000;
         b_sel = 4'(8 + i);
         #1;
         chk($sformatf("R1 low loc %0d", i), bus_a, 16'h0000);
         chk($sformatf("R1 high loc %0d", 8 + i), bus_b, 16'h0000);
      end

      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         drive(VECS[v].we, VECS[v].ds, VECS[v].di, VECS[v].as, VECS[v].ai,
               VECS[v].bs, VECS[v].bi, VECS[v].wd);
         #1;
         chk($sformatf("R4 table row %0d bus_a", v), bus_a, VECS[v].ea);
         chk($sformatf("R5 table row %0d bus_b", v), bus_b, VECS[v].eb);
      end

      // R7: after the last write edge the new value of R7 location shows
      @(negedge clk);
      drive(1'b0, 4'd0, 3'd0, 4'b0000, 3'd7, 4'b1000, 3'd0, 16'hBEEF);
      #1;
      chk("R7 new value after edge", bus_a, 16'h1234);
      chk("R6 scratch 8 unchanged", bus_b, 16'h8888);

      // R9: reset together with a write to location 10
      @(negedge clk);
      rst = 1'b1;
      drive(1'b1, 4'b1010, 3'd0, 4'b1010, 3'd0, 4'b0000, 3'd7, 16'hAAAA);
      @(negedge clk);
      rst = 1'b0;
      drive(1'b0, 4'b0000, 3'd0, 4'b1010, 3'd0, 4'b0000, 3'd7, 16'h0000);
      #1;
      chk("R9 reset beats write", bus_a, 16'h0000);
      chk("R1 reset clears location 7", bus_b, 16'h0000);

      // R3: dst_ir ignored with literal destination; low half untouched
      @(negedge clk);
      drive(1'b1, 4'b1001, 3'd5, 4'b0000, 3'd5, 4'b0000, 3'd1, 16'h4321);
      @(negedge clk);
      drive(1'b0, 4'b0000, 3'd0, 4'b0000, 3'd5, 4'b0000, 3'd1, 16'h0000);
      #1;
      chk("R3 location 5 untouched", bus_a, 16'h0000);
      chk("R3 location 1 untouched", bus_b, 16'h0000);
      a_sel = 4'b1001;
      #1;
      chk("R3 location 9 written", bus_a, 16'h4321);

      // R6: wr_en low with data present leaves location 9
      @(negedge clk);
      drive(1'b0, 4'b1001, 3'd0, 4'b1001, 3'd0, 4'b1001, 3'd0, 16'hFFFF);
      @(negedge clk);
      #1;
      chk("R6 no write when disabled", bus_a, 16'h4321);
      chk("R8 both ports same location", bus_b, 16'h4321);

      finish_run();
   end

   initial begin
      #(20 * 100000);
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end
endmodule